// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block fetches one cache line from a single-ported main memory after a cache miss. Every memory access costs a one-cycle address phase, a fixed wait while the memory works, and a one-cycle data-return phase. The sequencer drives the address phase itself, counts off the wait, and captures the returned data in the return cycle. There is no handshake on the memory side.

A parameter selects how the memory is attached. With a narrow attachment the data bus is one word wide, so the four words of a line are fetched one after another. Each word pays a full address, wait and return round trip, and no two trips overlap. With a wide attachment the bus carries the whole line, so a single round trip fills it.

The captured words are assembled into a line buffer. When the last return has been captured, the cache sees a one-cycle completion pulse. A cycle counter records how long the refill took and keeps that value until the next refill starts.

Top module: `line_refill_seq`

## Requirements
- R1: While reset is asserted, and after its release, `miss_ready` is 1, `mem_req` is 0, `refill_done` is 0 and `refill_cycles` is 0.
- R2: A miss is accepted at a clock edge where `miss_valid` and `miss_ready` are both 1. The first address phase (`mem_req` = 1) occupies the cycle right after that edge. Every address phase lasts exactly one cycle.
- R3: In narrow mode (`WIDE` = 0) a refill makes four accesses. Their `mem_addr` values are the line base plus 0, 1, 2 and 3, in that order. Each address phase starts 17 cycles after the previous one (1 address + 15 wait + 1 return), so the accesses never overlap.
- R4: The line base is the miss address (a word address) with its two lowest bits forced to 0.
- R5: Data is sampled from `mem_rdata` in the return cycle, which is 16 cycles after its address phase. In narrow mode bits [31:0] go to the word at that access's offset. In wide mode `mem_rdata[32*i+31:32*i]` goes to word i. Word i occupies `line_data[32*i+31:32*i]`.
- R6: `refill_done` is high for exactly one cycle, the cycle after the last return cycle. In that cycle `line_data` holds every word of the line.
- R7: `refill_cycles` returns to 0 when a miss is accepted and counts the cycles of the refill. In the `refill_done` cycle it reads 68 in narrow mode and 17 in wide mode, and it keeps that value until the next miss is accepted.
- R8: `miss_ready` is 1 only when no refill is in progress, and it is 0 in the `refill_done` cycle. A `miss_valid` seen while `miss_ready` is 0 has no effect on the address sequence.
- R9: In wide mode (`WIDE` = 1) a refill makes exactly one access, at the line base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache requests a line refill |
| miss_addr | input | ADDR_W | Word address of the missing word |
| miss_ready | output | 1 | Sequencer is idle and will accept a miss |
| mem_req | output | 1 | Address phase to memory |
| mem_addr | output | ADDR_W | Word address driven during the address phase |
| mem_rdata | input | WORDS*WORD_W | Memory return data (low word only in narrow mode) |
| line_data | output | WORDS*WORD_W | Assembled line buffer |
| refill_done | output | 1 | One-cycle completion pulse |
| refill_cycles | output | CNT_W | Length of the current or last refill in cycles |

## Verification
The bench builds a narrow and a wide instance side by side and drives both with the same miss stream. A memory responder puts valid data on the bus only in the exact return cycle and drives inverted data at all other times, so a capture one cycle early or late gives a wrong word.

The stream includes an aligned address and an address with offset 3, which together separate correct alignment from a raw pass-through. A request raised mid-refill shows whether a busy sequencer ignores input. A request held through the completion cycle, and a long continuous request at the top of the address space, test back-to-back acceptance and the wrap of the offset bits.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_WAIT = 3'd2,
    PH_RET  = 3'd3,
    PH_DONE = 3'd4
  } refill_phase_e;
endpackage

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
#(
  parameter int LAT   = 15,
  parameter int BEATS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output refill_phase_e    phase,
  output logic [IDX_W-1:0] beat
);
  localparam int LC_W = (LAT > 1) ? $clog2(LAT) : 1;

  refill_phase_e    state_q, state_n;
  logic [LC_W-1:0]  lat_q, lat_n;
  logic [IDX_W-1:0] beat_q, beat_n;
  logic             state_en, lat_en, beat_en;

  // next-state logic
  always_comb begin
    state_n = state_q;
    lat_n   = lat_q;
    beat_n  = beat_q;
    case (state_q)
      PH_IDLE: if (start) begin
        state_n = PH_ADDR;
        beat_n  = '0;
      end
      PH_ADDR: begin
        state_n = PH_WAIT;
        lat_n   = LC_W'(LAT - 1);
      end
      PH_WAIT: begin
        if (lat_q == '0) state_n = PH_RET;
        else             lat_n   = lat_q - 1'b1;
      end
      PH_RET: begin
        if (beat_q == IDX_W'(BEATS - 1)) begin
          state_n = PH_DONE;
        end else begin
          state_n = PH_ADDR;
          beat_n  = beat_q + 1'b1;
        end
      end
      PH_DONE: state_n = PH_IDLE;
      default: state_n = PH_IDLE;
    endcase
  end

  assign state_en = (state_n != state_q);
  assign lat_en   = (state_q == PH_ADDR) || (state_q == PH_WAIT);
  assign beat_en  = ((state_q == PH_IDLE) && start) || (state_q == PH_RET);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      lat_q   <= '0;
      beat_q  <= '0;
    end else begin
      if (state_en) state_q <= state_n;
      if (lat_en)   lat_q   <= lat_n;
      if (beat_en)  beat_q  <= beat_n;
    end
  end

  assign phase = state_q;
  assign beat  = beat_q;
endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter bit WIDE   = 1'b0,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [IDX_W-1:0]        beat,
  input  logic [WORDS*WORD_W-1:0] rdata,
  output logic [WORDS*WORD_W-1:0] line
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic              we;
    logic [WORD_W-1:0] wd;
    logic [WORD_W-1:0] word_q;
    if (WIDE) begin : g_wide
      assign we = capture;
      assign wd = rdata[i*WORD_W +: WORD_W];
    end else begin : g_narrow
      assign we = capture && (beat == IDX_W'(i));
      assign wd = rdata[WORD_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (we) word_q <= wd;
    end
    assign line[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/refill_cyccnt.sv
module refill_cyccnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_n = clear ? '0 : cnt_q + 1'b1;
  end
  assign cnt_en = clear || inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign count = cnt_q;
endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LAT    = 15,
  parameter bit WIDE   = 1'b0,
  localparam int OFF_W = $clog2(WORDS),
  localparam int BEATS = WIDE ? 1 : WORDS,
  localparam int TOTAL = BEATS * (LAT + 2),
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    miss_ready,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [WORDS*WORD_W-1:0] mem_rdata,
  output logic [WORDS*WORD_W-1:0] line_data,
  output logic                    refill_done,
  output logic [CNT_W-1:0]        refill_cycles
);
  refill_phase_e           phase;
  logic [OFF_W-1:0]        beat;
  logic                    accept;
  logic [ADDR_W-OFF_W-1:0] tag_q;

  assign miss_ready = (phase == PH_IDLE);
  assign accept     = miss_valid && miss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (accept) tag_q <= miss_addr[ADDR_W-1:OFF_W];
  end

  refill_fsm #(.LAT(LAT), .BEATS(BEATS), .IDX_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .phase(phase), .beat(beat)
  );

  refill_linebuf #(.WORD_W(WORD_W), .WORDS(WORDS), .WIDE(WIDE), .IDX_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .capture(phase == PH_RET), .beat(beat),
    .rdata(mem_rdata), .line(line_data)
  );

  refill_cyccnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .inc((phase == PH_ADDR) || (phase == PH_WAIT) || (phase == PH_RET)),
    .count(refill_cycles)
  );

  assign mem_req     = (phase == PH_ADDR);
  assign mem_addr    = WIDE ? {tag_q, {OFF_W{1'b0}}} : {tag_q, beat};
  assign refill_done = (phase == PH_DONE);
endmodule

// File: rtl/refill_chk.sv
module refill_chk #(
  parameter bit WIDE  = 1'b0,
  parameter int WORDS = 4,
  parameter int LAT   = 15,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             mem_req,
  input logic             refill_done,
  input logic [CNT_W-1:0] refill_cycles
);
  localparam int TOTAL = (WIDE ? 1 : WORDS) * (LAT + 2);

  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (mem_req)            gap_q <= '0;
      else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
      if (refill_done)        seen_q <= 1'b0;
      else if (mem_req)       seen_q <= 1'b1;
    end
  end

  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r3_req_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && seen_q) |-> (gap_q == 16'(LAT + 1)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |=> !refill_done);

  a_r7_total_len: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (refill_cycles == CNT_W'(TOTAL)));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ready && !miss_valid) |=> $stable(refill_cycles));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || refill_done) |-> !miss_ready);
endmodule

bind line_refill_seq refill_chk #(.WIDE(WIDE), .WORDS(WORDS), .LAT(LAT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .mem_req(mem_req), .refill_done(refill_done), .refill_cycles(refill_cycles)
);

// File: tb/tb_line_refill_seq.sv
module tb_line_refill_seq;
  localparam int AW = 32;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int RT = 17;

  logic clk, rst_n, miss_valid;
  logic [AW-1:0] miss_addr;

  logic n_ready, n_req, n_done, w_ready, w_req, w_done;
  logic [AW-1:0] n_addr, w_addr;
  logic [NW*WW-1:0] n_rdata, w_rdata, n_line, w_line;
  logic [6:0] n_cyc;
  logic [4:0] w_cyc;

  int checks = 0;
  int fails  = 0;

  line_refill_seq #(.WIDE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(n_ready), .mem_req(n_req), .mem_addr(n_addr), .mem_rdata(n_rdata),
    .line_data(n_line), .refill_done(n_done), .refill_cycles(n_cyc));

  line_refill_seq #(.WIDE(1'b1)) dut_wide (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(w_ready), .mem_req(w_req), .mem_addr(w_addr), .mem_rdata(w_rdata),
    .line_data(w_line), .refill_done(w_done), .refill_cycles(w_cyc));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
    return a * 32'h9E37_79B1 + 32'h0001_3579;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state, index 0 = narrow, 1 = wide
  bit            act_m [2];
  int            t_m   [2];
  int            cyc_m [2];
  logic [AW-1:0] base_m[2];
  int            rdc   [2];
  logic [AW-1:0] rda   [2];
  int            beats [2] = '{NW, 1};

  task automatic tick();
    bit pv;
    logic [AW-1:0] pa;
    @(negedge clk);
    pv = miss_valid;
    pa = miss_addr;
    for (int m = 0; m < 2; m++) begin
      bit            r, d, rdy;
      logic [AW-1:0] a;
      logic [6:0]    c;
      logic [NW*WW-1:0] ln;
      bit            er, ed;
      logic [NW*WW-1:0] dat;
      // advance model by one clock edge
      if (!rst_n) begin
        act_m[m] = 0; t_m[m] = 0; cyc_m[m] = 0;
      end else if (act_m[m]) begin
        if (t_m[m] == beats[m] * RT) act_m[m] = 0;
        else begin t_m[m]++; cyc_m[m] = t_m[m]; end
      end else if (pv) begin
        act_m[m] = 1; t_m[m] = 0; cyc_m[m] = 0;
        base_m[m] = {pa[AW-1:2], 2'b00};
      end
      r   = (m == 0) ? n_req   : w_req;
      d   = (m == 0) ? n_done  : w_done;
      rdy = (m == 0) ? n_ready : w_ready;
      a   = (m == 0) ? n_addr  : w_addr;
      c   = (m == 0) ? n_cyc   : 7'(w_cyc);
      ln  = (m == 0) ? n_line  : w_line;
      er  = act_m[m] && (t_m[m] % RT == 0) && (t_m[m] / RT < beats[m]);
      ed  = act_m[m] && (t_m[m] == beats[m] * RT);
      chk(rdy == !act_m[m], "R1 R8 miss_ready", 64'(rdy), 64'(!act_m[m]));
      chk(r == er, "R2 mem_req", 64'(r), 64'(er));
      if (r && er) begin
        if (m == 0) chk(a == base_m[m] + AW'(t_m[m] / RT), "R3 R4 R8 mem_addr", 64'(a), 64'(base_m[m] + AW'(t_m[m] / RT)));
        else        chk(a == base_m[m], "R9 R4 R8 mem_addr", 64'(a), 64'(base_m[m]));
      end
      chk(d == ed, "R6 refill_done", 64'(d), 64'(ed));
      chk(c == 7'(cyc_m[m]), "R7 refill_cycles", 64'(c), 64'(cyc_m[m]));
      if (d && ed) begin
        for (int i = 0; i < NW; i++)
          chk(ln[i*WW +: WW] == mem_word(base_m[m] + AW'(i)), "R5 R6 line word",
              64'(ln[i*WW +: WW]), 64'(mem_word(base_m[m] + AW'(i))));
      end
      // memory responder: valid data only in the return cycle
      dat = '0;
      for (int i = 0; i < NW; i++) dat[i*WW +: WW] = ~mem_word(rda[m] + AW'(i));
      if (r) begin
        rdc[m] = 16; rda[m] = a;
      end else if (rdc[m] > 0) begin
        rdc[m]--;
        if (rdc[m] == 0)
          for (int i = 0; i < NW; i++) dat[i*WW +: WW] = mem_word(rda[m] + AW'(i));
      end
      if (m == 0) n_rdata = dat; else w_rdata = dat;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0;
    n_rdata = '0; w_rdata = '0;
    rdc = '{0, 0}; rda = '{'0, '0};
    run(3);
    chk(n_ready && !n_req && !n_done && n_cyc == 0, "R1 narrow reset", 64'({n_ready, n_req, n_done}), 64'(3'b100));
    chk(w_ready && !w_req && !w_done && w_cyc == 0, "R1 wide reset", 64'({w_ready, w_req, w_done}), 64'(3'b100));
    rst_n = 1'b1;
    run(2);
    // aligned miss
    miss_valid = 1'b1; miss_addr = 32'h0000_0100;
    run(1);
    miss_valid = 1'b0;
    run(80);
    // unaligned miss, then request while busy (must be ignored)
    miss_valid = 1'b1; miss_addr = 32'h0000_1237;
    run(1);
    miss_valid = 1'b0;
    run(5);
    miss_valid = 1'b1; miss_addr = 32'hAAAA_AAA8;
    run(10);
    miss_valid = 1'b0;
    run(80);
    // continuous requests: back-to-back refills, top of address space
    miss_valid = 1'b1; miss_addr = 32'hFFFF_FFFE;
    run(150);
    miss_addr = 32'h0000_0005;
    run(100);
    miss_valid = 1'b0;
    run(80);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule